// File: doc/BRIEF.md
# Serial SAR ADC Conversion and Readout Sequencer

This block drives a serial successive-approximation converter from the controller side. For each conversion it pulls the active-low convert strobe low for a fixed time, which sets the instant the input is sampled. It then opens a separate serial frame by taking the active-low frame select low. It runs a divided serial clock and shifts in one result word, most significant bit first. Every delay comes from a cycle counter in the fast system clock domain. With the defaults that clock is 100 MHz, giving a 50 ns convert pulse, a 25 MHz serial clock and a 1 µs minimum spacing between conversions.

On the user side there is a one-cycle `start` request and a level `cont` that keeps the converter running back to back. Results come out on `result`, qualified by a one-cycle `result_vld`. A request that arrives while a cycle is running, or before the minimum spacing has passed, is dropped and is not queued.

Top module: `sar_readout_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `conv_n`=1, `frame_n`=1, `ser_clk`=0 and `result_vld`=0. The spacing timer is cleared, so a request right after reset is accepted.
- R2: Each conversion drives `conv_n` low for exactly CONV_LOW_CYC system clocks (default 5, which is 50 ns).
- R3: `frame_n` falls in the same cycle that `conv_n` returns high. It falls before the first rising edge of `ser_clk`. That rising edge comes at least SETUP_CYC clocks (default 4) after `conv_n` fell.
- R4: `ser_clk` idles low and is high only while `frame_n` is low. Its period is DIV clocks (default 4) and it is high for DIV/2 of them. Each frame has exactly BITS rising edges (default 16).
- R5: `ser_din` is sampled at each falling edge of `ser_clk`. The first bit sampled is result bit BITS-1 and the last is bit 0.
- R6: At the last falling edge, `frame_n` rises and `result_vld` is high for one cycle with the new `result`. `result` then holds until the next frame completes.
- R7: `frame_n` stays high for at least DIV clocks between two frames.
- R8: Two falling edges of `conv_n` are at least SPACING_CYC clocks apart (default 100, which is 21 periods of a 21 MHz converter clock, rounded up).
- R9: A `start` that arrives while a cycle is in progress, or before the spacing has elapsed, produces no conversion and is not remembered.
- R10: When idle with the spacing elapsed, `start` or `cont` makes `conv_n` fall at the next clock edge. With `cont` held high, conversions repeat every max(SPACING_CYC, cycle length) clocks; with the defaults this is exactly 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle conversion request |
| cont | input | 1 | Level: convert continuously while high |
| ser_din | input | 1 | Serial data from the converter |
| conv_n | output | 1 | Active-low convert strobe |
| frame_n | output | 1 | Active-low serial frame select |
| ser_clk | output | 1 | Serial clock, idle low |
| result | output | BITS | Last received conversion word |
| result_vld | output | 1 | One-cycle pulse when `result` is new |

## Verification
The checker watches the protocol on every cycle:
- the convert pulse width;
- the setup time from the convert edge to the serial clock;
- the minimum spacing between conversions;
- the serial clock staying inside the frame;
- the gap between frames;
- the pairing of the frame's end with a one-cycle valid.

The bench scenarios show what a property cannot:
- the bit order and value of the received word, using an ADC model and a scoreboard;
- that ignored requests leave no conversion behind;
- the exact repeat interval in continuous mode;
- recovery from a reset in the middle of a frame.

// File: rtl/sar_seq_pkg.sv
// Package: shared types and helpers for the SAR readout sequencer.
// Assumes nothing beyond IEEE 1800-2017 constant functions.
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_SETUP,
        ST_SHIFT,
        ST_GAP
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sar_seq_pace.sv
// Conversion spacing timer. It is loaded when a conversion starts and counts
// down to zero. `ready` is high once SPACING_CYC clocks have passed since the
// load. Assumes SPACING_CYC >= 1.
module sar_seq_pace #(
    parameter int SPACING_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic ready
);
    localparam int CW = $clog2(SPACING_CYC + 1);

    logic [CW-1:0] remain;

    // Count down from the load value; a reset leaves the timer expired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= CW'(SPACING_CYC - 1);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign ready = (remain == '0);

endmodule

// File: rtl/sar_seq_sclk.sv
// Serial clock generator. While `run` is high it divides the system clock by
// DIV. The first rising edge comes one clock after `run` rises, and the clock
// is high for DIV/2 cycles of each period. `fall_now` marks the edge at which
// the serial clock drops, which is also the data capture edge.
// Assumes DIV is even and >= 2.
module sar_seq_sclk #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ser_clk,
    output logic fall_now
);
    localparam int HALF = DIV / 2;
    localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] phase;

    // Advance the phase and toggle the clock at phase 0 and at the half point.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase   <= '0;
            ser_clk <= 1'b0;
        end else begin
            phase <= (phase == PW'(DIV - 1)) ? '0 : phase + 1'b1;
            if (phase == '0) begin
                ser_clk <= 1'b1;
            end else if (phase == PW'(HALF)) begin
                ser_clk <= 1'b0;
            end
        end
    end

    assign fall_now = run && (phase == PW'(HALF));

endmodule

// File: rtl/sar_seq_shift.sv
// Input shift register. It samples `din` at each capture strobe and loads
// the bits MSB first. After BITS strobes it updates `result` and pulses
// `result_vld` for one cycle. `last_bit` flags the strobe that completes the
// word. Assumes BITS >= 2.
module sar_seq_shift #(
    parameter int BITS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            fall_now,
    input  logic            din,
    output logic            last_bit,
    output logic [BITS-1:0] result,
    output logic            result_vld
);
    localparam int CW = $clog2(BITS);

    logic [BITS-1:0] shreg;
    logic [CW-1:0]   bit_cnt;
    logic [BITS-1:0] shreg_nx;

    assign shreg_nx = {shreg[BITS-2:0], din};
    assign last_bit = run && fall_now && (bit_cnt == CW'(BITS - 1));

    // Shift on each capture strobe and publish the word after the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_cnt    <= '0;
            result     <= '0;
            result_vld <= 1'b0;
        end else begin
            result_vld <= 1'b0;
            if (!run) begin
                bit_cnt <= '0;
            end else if (fall_now) begin
                shreg <= shreg_nx;
                if (bit_cnt == CW'(BITS - 1)) begin
                    result     <= shreg_nx;
                    result_vld <= 1'b1;
                    bit_cnt    <= '0;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sar_readout_seq.sv
// SAR ADC conversion and readout sequencer (top).
// Sequence per conversion: convert strobe low for CONV_LOW_CYC clocks. Then the
// frame select falls and, after a short setup, the serial clock runs for BITS
// periods while data is captured on its falling edges. The frame then closes
// and the frame select stays high for FRAME_GAP_CYC clocks. A new conversion
// may start only when idle and once the spacing timer has expired.
// Assumes every *_CYC parameter is >= 1 and DIV is even.
module sar_readout_seq
    import sar_seq_pkg::*;
#(
    parameter int BITS          = 16,
    parameter int DIV           = 4,
    parameter int CONV_LOW_CYC  = 5,
    parameter int SETUP_CYC     = 4,
    parameter int SPACING_CYC   = 100,
    parameter int FRAME_GAP_CYC = DIV
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cont,
    input  logic            ser_din,
    output logic            conv_n,
    output logic            frame_n,
    output logic            ser_clk,
    output logic [BITS-1:0] result,
    output logic            result_vld
);
    // Setup clocks still needed after the convert pulse (at least one).
    localparam int SETUP_REM = (SETUP_CYC > CONV_LOW_CYC) ? (SETUP_CYC - CONV_LOW_CYC) : 1;
    localparam int TMAX      = imax(imax(CONV_LOW_CYC, SETUP_REM), FRAME_GAP_CYC);
    localparam int TW        = $clog2(TMAX + 1);

    seq_state_e    state;
    logic [TW-1:0] tcnt;
    logic          pace_ready;
    logic          launch;
    logic          shift_run;
    logic          capture;
    logic          last_bit;

    assign launch    = (state == ST_IDLE) && (start || cont) && pace_ready;
    assign shift_run = (state == ST_SHIFT);

    sar_seq_pace #(
        .SPACING_CYC (SPACING_CYC)
    ) u_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (launch),
        .ready (pace_ready)
    );

    sar_seq_sclk #(
        .DIV (DIV)
    ) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (shift_run),
        .ser_clk  (ser_clk),
        .fall_now (capture)
    );

    sar_seq_shift #(
        .BITS (BITS)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (shift_run),
        .fall_now   (capture),
        .din        (ser_din),
        .last_bit   (last_bit),
        .result     (result),
        .result_vld (result_vld)
    );

    // Sequence the phases of a conversion and drive the registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            tcnt    <= '0;
            conv_n  <= 1'b1;
            frame_n <= 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    tcnt <= '0;
                    if (launch) begin
                        conv_n <= 1'b0;
                        state  <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (tcnt == TW'(CONV_LOW_CYC - 1)) begin
                        conv_n  <= 1'b1;
                        frame_n <= 1'b0;
                        tcnt    <= '0;
                        state   <= ST_SETUP;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (tcnt == TW'(SETUP_REM - 1)) begin
                        tcnt  <= '0;
                        state <= ST_SHIFT;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (last_bit) begin
                        frame_n <= 1'b1;
                        tcnt    <= '0;
                        state   <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (tcnt == TW'(FRAME_GAP_CYC - 1)) begin
                        tcnt  <= '0;
                        state <= ST_IDLE;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/sar_seq_chk.sv
// Protocol checker for sar_readout_seq, attached by bind. It keeps its own
// interval counters so that no property needs a parameter-sized delay.
module sar_seq_chk #(
    parameter int DIV          = 4,
    parameter int CONV_LOW_CYC = 5,
    parameter int SETUP_CYC    = 4,
    parameter int SPACING_CYC  = 100
) (
    input logic clk,
    input logic rst_n,
    input logic conv_n,
    input logic frame_n,
    input logic ser_clk,
    input logic result_vld
);
    localparam int SAT = SPACING_CYC + SETUP_CYC + DIV + CONV_LOW_CYC;
    localparam int SW  = $clog2(SAT + 1);

    logic [SW-1:0] low_len;
    logic [SW-1:0] since_conv;
    logic [SW-1:0] hi_len;
    logic          conv_q;
    logic          sclk_q;

    // Track the convert-low length, the time since the last convert edge, and
    // the frame-high time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_len    <= '0;
            since_conv <= SW'(SAT);
            hi_len     <= SW'(SAT);
            conv_q     <= 1'b1;
            sclk_q     <= 1'b0;
        end else begin
            conv_q  <= conv_n;
            sclk_q  <= ser_clk;
            low_len <= conv_n ? '0 : low_len + 1'b1;
            if (conv_q && !conv_n) begin
                since_conv <= SW'(1);
            end else if (since_conv != SW'(SAT)) begin
                since_conv <= since_conv + 1'b1;
            end
            if (!frame_n) begin
                hi_len <= '0;
            end else if (hi_len != SW'(SAT)) begin
                hi_len <= hi_len + 1'b1;
            end
        end
    end

    a_r2_conv_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_n) |-> (low_len == SW'(CONV_LOW_CYC)));

    a_r3_sclk_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && !sclk_q) |-> (since_conv >= SW'(SETUP_CYC)));

    a_r3_quiet_during_conv: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_n |-> !ser_clk);

    a_r4_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !frame_n);

    a_r6_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld |=> !result_vld);

    a_r6_frame_end_vld: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_n) |-> result_vld);

    a_r7_frame_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> (hi_len >= SW'(DIV)));

    a_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_q && !conv_n) |-> (since_conv >= SW'(SPACING_CYC)));

endmodule

bind sar_readout_seq sar_seq_chk #(
    .DIV          (DIV),
    .CONV_LOW_CYC (CONV_LOW_CYC),
    .SETUP_CYC    (SETUP_CYC),
    .SPACING_CYC  (SPACING_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_n     (conv_n),
    .frame_n    (frame_n),
    .ser_clk    (ser_clk),
    .result_vld (result_vld)
);

// File: tb/sar_readout_seq_tb.sv
// Scoreboard bench: the driver queues expected words, an ADC model serves them
// bit by bit, and monitors compare results and protocol timing.
module sar_readout_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BITS       = 16;
    localparam int DIV        = 4;
    localparam int CONV_LOW   = 5;
    localparam int SETUP      = 4;
    localparam int SPACING    = 100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            cont = 1'b0;
    logic            ser_din = 1'b0;
    logic            conv_n;
    logic            frame_n;
    logic            ser_clk;
    logic [BITS-1:0] result;
    logic            result_vld;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [BITS-1:0] exp_q[$];
    logic [BITS-1:0] adc_q[$];
    logic [BITS-1:0] adc_sh = '0;

    int n_conv = 0;
    int last_gap = 0;

    sar_readout_seq #(
        .BITS         (BITS),
        .DIV          (DIV),
        .CONV_LOW_CYC (CONV_LOW),
        .SETUP_CYC    (SETUP),
        .SPACING_CYC  (SPACING)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cont       (cont),
        .ser_din    (ser_din),
        .conv_n     (conv_n),
        .frame_n    (frame_n),
        .ser_clk    (ser_clk),
        .result     (result),
        .result_vld (result_vld)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // ADC model: present the MSB when the frame opens, the next bit after each fall.
    initial forever begin
        @(negedge frame_n);
        adc_sh  = (adc_q.size() != 0) ? adc_q.pop_front() : '0;
        ser_din = adc_sh[BITS-1];
    end
    initial forever begin
        @(negedge ser_clk);
        #1;
        adc_sh  = {adc_sh[BITS-2:0], 1'b0};
        ser_din = adc_sh[BITS-1];
    end

    // Monitor: scoreboard compare and protocol timing, sampled at falling clk.
    initial begin
        logic pc = 1'b1, pf = 1'b1, ps = 1'b0, pv = 1'b0;
        int t_cf = 0, t_fr = 0, t_sr = 0, rises = 0;
        bit have_c = 0, have_f = 0;
        logic [BITS-1:0] last_res = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                have_c = 0; have_f = 0; rises = 0; last_res = '0;
            end else begin
                if (pc && !conv_n) begin
                    n_conv++;
                    if (have_c) begin
                        last_gap = cyc - t_cf;
                        chk(last_gap >= SPACING, "R8", "conv spacing", last_gap, SPACING);
                    end
                    chk(result == last_res, "R6", "result held", result, last_res);
                    t_cf = cyc; have_c = 1;
                end
                if (!pc && conv_n) begin
                    chk(cyc - t_cf == CONV_LOW, "R2", "conv low width", cyc - t_cf, CONV_LOW);
                    chk(frame_n == 1'b0, "R3", "frame falls with conv rise", frame_n, 0);
                end
                if (!ps && ser_clk) begin
                    chk(frame_n == 1'b0, "R4", "sclk inside frame", frame_n, 0);
                    if (rises == 0)
                        chk(cyc - t_cf >= SETUP, "R3", "setup to first sclk", cyc - t_cf, SETUP);
                    else
                        chk(cyc - t_sr == DIV, "R4", "sclk period", cyc - t_sr, DIV);
                    t_sr = cyc; rises++;
                end
                if (ps && !ser_clk)
                    chk(cyc - t_sr == DIV / 2, "R4", "sclk high time", cyc - t_sr, DIV / 2);
                if (!pf && frame_n) begin
                    chk(rises == BITS, "R4", "sclk rises per frame", rises, BITS);
                    rises = 0; t_fr = cyc; have_f = 1;
                end
                if (pf && !frame_n && have_f)
                    chk(cyc - t_fr >= DIV, "R7", "frame high gap", cyc - t_fr, DIV);
                if (result_vld) begin
                    chk(!pv, "R6", "valid one cycle", pv, 0);
                    chk(frame_n == 1'b1, "R6", "frame closed at valid", frame_n, 1);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5", "unexpected result", result, 0);
                    end else begin
                        logic [BITS-1:0] e;
                        e = exp_q.pop_front();
                        chk(result == e, "R5", "result word", result, e);
                    end
                    last_res = result;
                end
            end
            pc = conv_n; pf = frame_n; ps = ser_clk; pv = result_vld;
        end
    end

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_empty();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_conv(input logic [BITS-1:0] w);
        adc_q.push_back(w);
        exp_q.push_back(w);
        pulse_start();
        wait_empty();
        repeat (40) @(negedge clk);
    endtask

    task automatic check_idle(input string what);
        chk(conv_n == 1'b1, "R1", {what, " conv_n"}, conv_n, 1);
        chk(frame_n == 1'b1, "R1", {what, " frame_n"}, frame_n, 1);
        chk(ser_clk == 1'b0, "R1", {what, " ser_clk"}, ser_clk, 0);
        chk(result_vld == 1'b0, "R1", {what, " result_vld"}, result_vld, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        check_idle("in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10: idle and ready -> conv_n low after the next edge.
        adc_q.push_back(16'hA5C3);
        exp_q.push_back(16'hA5C3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(conv_n == 1'b0, "R10", "immediate accept", conv_n, 0);
        wait_empty();
        repeat (40) @(negedge clk);

        // R5: distinct bit patterns.
        do_conv(16'hFFFF);
        do_conv(16'h0000);
        do_conv(16'h8001);
        do_conv(16'h1234);

        // R9: requests while busy and before the spacing are dropped.
        n0 = n_conv;
        adc_q.push_back(16'h3C96);
        exp_q.push_back(16'h3C96);
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        wait_empty();
        repeat (5) @(negedge clk);
        pulse_start();
        repeat (60) @(negedge clk);
        chk(n_conv == n0 + 1, "R9", "ignored requests", n_conv - n0, 1);

        // R10: continuous mode repeats at the spacing interval.
        n0 = n_conv;
        adc_q.push_back(16'h0F0F); exp_q.push_back(16'h0F0F);
        adc_q.push_back(16'hF0F0); exp_q.push_back(16'hF0F0);
        adc_q.push_back(16'h5555); exp_q.push_back(16'h5555);
        adc_q.push_back(16'hAAAA); exp_q.push_back(16'hAAAA);
        cont = 1'b1;
        wait_empty();
        cont = 1'b0;
        chk(last_gap == SPACING, "R10", "continuous interval", last_gap, SPACING);
        repeat (150) @(negedge clk);
        chk(n_conv == n0 + 4, "R10", "continuous count", n_conv - n0, 4);

        // R1: reset in the middle of a frame.
        adc_q.push_back(16'h6E2D);
        pulse_start();
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("mid-frame reset");
        adc_q.delete();
        exp_q.delete();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        adc_q.push_back(16'h7E81);
        exp_q.push_back(16'h7E81);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(conv_n == 1'b0, "R1", "accept right after reset", conv_n, 0);
        wait_empty();
        repeat (10) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule